// File: doc/BRIEF.md
# Reordering Memory Request Queue

This block sits between the request side of a memory subsystem and a single downstream command port. Read requests and write requests come in on two separate valid/ready channels, each carrying an address and a transaction ID. Each kind is held in its own associative store, by default 32 slots deep. Every slot of a store can be compared against an address in the same cycle. Each cycle the block sends one command out, picked for efficiency rather than by arrival: it prefers work that stays in the memory row it touched last. When nothing is queued, a request that arrives goes straight to the output in the same cycle.

Reordering is bounded by two rules. A read may not pass an older write that covers the same address granule, because that read would return stale data. Requests of the same kind that share an ID leave in the order they arrived. The granule size and the row boundary are parameters, so one design serves several address maps.

Top module: `mem_reorder_q`

## Requirements
- R1: After reset, `cmd_valid` is 0 and both `rd_ready` and `wr_ready` are 1.
- R2: When both stores are empty, an arriving request appears on the command port in the same cycle. If `cmd_ready` is 1 in that cycle, the request is consumed without being stored, and `cmd_valid` is 0 on the next cycle.
- R3: Each store holds at most DEPTH requests (32 by default). The store's ready output is 0 exactly while it holds DEPTH requests. A full read store does not stop write requests being accepted.
- R4: Among issuable queued requests, one whose row, `addr >> ROW_LSB`, equals the row of the previous command is issued first. When several qualify, the oldest of them goes first.
- R5: When no issuable queued request hits the previous row, the oldest issuable request across both stores is issued.
- R6: A read is never issued while an older write with the same granule, `addr >> GRAN_LG`, is still queued, even when the read hits the previous row.
- R7: Reads that share an ID issue in arrival order. Writes that share an ID also issue in arrival order.
- R8: When a read and a write arrive in the same cycle, the write counts as older. With both stores empty, the write takes the same-cycle path and the read is queued.
- R9: While either store holds a request, `cmd_valid` is 1.
- R10: `cmd_write` is 1 for a write command and 0 for a read command. `cmd_addr` and `cmd_id` carry the request's own address and ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read store can accept |
| rd_addr | input | ADDR_W | Read byte address |
| rd_id | input | ID_W | Read transaction ID |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write store can accept |
| wr_addr | input | ADDR_W | Write byte address |
| wr_id | input | ID_W | Write transaction ID |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Command address |
| cmd_id | output | ID_W | Command transaction ID |

## Verification
The hardest case to reach is a read that the row preference would pull forward while an older write to the same granule is still queued. With the default sizes a granule lies inside one row, so the write always wins on age anyway and the hazard rule is never the deciding factor.

The bench therefore builds the block with a granule two rows wide. It first lets a lone read pass through to set the previous row. It then holds `cmd_ready` low while a write in the neighbouring row and a read in the previous row are loaded. A design that ignored the hazard would issue the read first.

A similar stall-and-load pattern makes a younger same-ID read hit the previous row, which checks the ID ordering rule.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  localparam int MRQ_SEQ_W = 16;
  typedef logic [MRQ_SEQ_W-1:0] mrq_seq_t;

  // arrival stamp a is earlier than b (wrap-aware)
  function automatic logic seq_before(input mrq_seq_t a, input mrq_seq_t b);
    mrq_seq_t d;
    d = a - b;
    return d[MRQ_SEQ_W-1];
  endfunction
endpackage

// File: rtl/mrq_pick.sv
module mrq_pick
  import mrq_pkg::*;
#(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]   cand,
  input  mrq_seq_t       stamp [N],
  output logic           any,
  output logic [IW-1:0]  idx
);
  mrq_seq_t best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || seq_before(stamp[i], best))) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = stamp[i];
      end
    end
  end
endmodule

// File: rtl/mrq_store.sv
module mrq_store
  import mrq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4,
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [ID_W-1:0]   push_id,
  input  mrq_seq_t          push_seq,
  input  logic [DEPTH-1:0]  push_xdep,
  input  logic [DEPTH-1:0]  pop_own,
  input  logic [DEPTH-1:0]  pop_x,
  output logic [DEPTH-1:0]  ent_vld,
  output logic [ADDR_W-1:0] ent_addr [DEPTH],
  output logic [ID_W-1:0]   ent_id   [DEPTH],
  output mrq_seq_t          ent_seq  [DEPTH],
  output logic [DEPTH-1:0]  ent_elig,
  output logic [DEPTH-1:0]  alloc_oh,
  output logic [CW-1:0]     cnt,
  output logic              full,
  output logic              empty
);
  logic [DEPTH-1:0] dep_own_q [DEPTH];
  logic [DEPTH-1:0] dep_x_q   [DEPTH];
  logic [DEPTH-1:0] new_own_dep;

  // lowest free slot
  always_comb begin
    alloc_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_vld[i]) begin
        alloc_oh    = '0;
        alloc_oh[i] = 1'b1;
      end
    end
  end

  // same-ID entries still pending after this cycle's issue
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      new_own_dep[i] = ent_vld[i] && !pop_own[i] && (ent_id[i] == push_id);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      ent_elig[i] = ent_vld[i] && (dep_own_q[i] == '0) && (dep_x_q[i] == '0);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < DEPTH; i++) cnt = cnt + CW'(ent_vld[i]);
  end

  assign full  = &ent_vld;
  assign empty = ~|ent_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_addr[i]  <= '0;
        ent_id[i]    <= '0;
        ent_seq[i]   <= '0;
        dep_own_q[i] <= '0;
        dep_x_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (pop_own[i]) begin
          ent_vld[i]   <= 1'b0;
          dep_own_q[i] <= '0;
          dep_x_q[i]   <= '0;
        end else if (push && alloc_oh[i]) begin
          ent_vld[i]   <= 1'b1;
          ent_addr[i]  <= push_addr;
          ent_id[i]    <= push_id;
          ent_seq[i]   <= push_seq;
          dep_own_q[i] <= new_own_dep;
          dep_x_q[i]   <= push_xdep;
        end else begin
          dep_own_q[i] <= dep_own_q[i] & ~pop_own;
          dep_x_q[i]   <= dep_x_q[i] & ~pop_x;
        end
      end
    end
  end
endmodule

// File: rtl/mem_reorder_q.sv
module mem_reorder_q
  import mrq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int DEPTH   = 32,
  parameter int GRAN_LG = 6,
  parameter int ROW_LSB = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ID_W-1:0]   rd_id,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ID_W-1:0]   wr_id,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [ID_W-1:0]   cmd_id
);
  localparam int LG    = $clog2(DEPTH);
  localparam int N2    = 2 * DEPTH;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int ROW_W = ADDR_W - ROW_LSB;

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ROW_LSB];
  endfunction

  function automatic logic same_gran(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    return (a >> GRAN_LG) == (b >> GRAN_LG);
  endfunction

  // store views
  logic [DEPTH-1:0]  wq_vld, wq_elig, wq_alloc, rq_vld, rq_elig, rq_alloc;
  logic [ADDR_W-1:0] wq_addr [DEPTH];
  logic [ADDR_W-1:0] rq_addr [DEPTH];
  logic [ID_W-1:0]   wq_id   [DEPTH];
  logic [ID_W-1:0]   rq_id   [DEPTH];
  mrq_seq_t          wq_seq  [DEPTH];
  mrq_seq_t          rq_seq  [DEPTH];
  logic [CW-1:0]     wq_cnt, rq_cnt;
  logic              wq_full, wq_empty, rq_full, rq_empty;

  // event wires
  logic              q_any, hit_any, sel_rd, q_fire, cmd_fire;
  logic              take_w_byp, take_r_byp, wr_push, rd_push, wr_acc, rd_acc;
  logic              rd_iss_hazard;
  logic [LG:0]       sel_idx, hit_idx, old_idx;
  logic [LG-1:0]     q_slot;
  logic [DEPTH-1:0]  pop_w, pop_r, rd_xdep;
  logic [N2-1:0]     all_elig, all_hit;
  mrq_seq_t          all_seq [N2];
  mrq_seq_t          seq_q, w_seq, r_seq;
  logic [ROW_W-1:0]  last_row_q;
  logic              last_vld_q;

  assign wr_ready = !wq_full;
  assign rd_ready = !rq_full;
  assign wr_acc   = wr_valid && wr_ready;
  assign rd_acc   = rd_valid && rd_ready;
  assign w_seq    = seq_q;
  assign r_seq    = seq_q + mrq_seq_t'(wr_acc);

  // candidate view: writes in low half, reads in high half
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      all_seq[i]         = wq_seq[i];
      all_seq[DEPTH + i] = rq_seq[i];
      all_elig[i]         = wq_elig[i];
      all_elig[DEPTH + i] = rq_elig[i];
      all_hit[i]         = wq_elig[i] && last_vld_q && (row_of(wq_addr[i]) == last_row_q);
      all_hit[DEPTH + i] = rq_elig[i] && last_vld_q && (row_of(rq_addr[i]) == last_row_q);
    end
  end

  mrq_pick #(.N(N2), .IW(LG + 1)) u_pick_hit (
    .cand(all_hit), .stamp(all_seq), .any(hit_any), .idx(hit_idx)
  );

  mrq_pick #(.N(N2), .IW(LG + 1)) u_pick_old (
    .cand(all_elig), .stamp(all_seq), .any(q_any), .idx(old_idx)
  );

  assign sel_idx = hit_any ? hit_idx : old_idx;
  assign sel_rd  = sel_idx[LG];
  assign q_slot  = sel_idx[LG-1:0];

  // output mux: queued work first, else same-cycle path (write preferred)
  always_comb begin
    if (q_any) begin
      cmd_valid = 1'b1;
      cmd_write = !sel_rd;
      cmd_addr  = sel_rd ? rq_addr[q_slot] : wq_addr[q_slot];
      cmd_id    = sel_rd ? rq_id[q_slot]   : wq_id[q_slot];
    end else begin
      cmd_valid = wq_empty && rq_empty && (wr_valid || rd_valid);
      cmd_write = wr_valid;
      cmd_addr  = wr_valid ? wr_addr : rd_addr;
      cmd_id    = wr_valid ? wr_id   : rd_id;
    end
  end

  assign cmd_fire   = cmd_valid && cmd_ready;
  assign q_fire     = cmd_fire && q_any;
  assign take_w_byp = cmd_fire && !q_any && wr_valid;
  assign take_r_byp = cmd_fire && !q_any && !wr_valid && rd_valid;
  assign wr_push    = wr_acc && !take_w_byp;
  assign rd_push    = rd_acc && !take_r_byp;
  assign pop_w      = (q_fire && !sel_rd) ? ({{(DEPTH-1){1'b0}}, 1'b1} << q_slot) : '0;
  assign pop_r      = (q_fire &&  sel_rd) ? ({{(DEPTH-1){1'b0}}, 1'b1} << q_slot) : '0;

  // hazard lookup: every write slot compared with the arriving read address
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      rd_xdep[i] = (wq_vld[i] && !pop_w[i] && same_gran(wq_addr[i], rd_addr)) ||
                   (wr_push && wq_alloc[i] && same_gran(wr_addr, rd_addr));
  end

  // independent view of the hazard at issue time, by arrival stamp
  always_comb begin
    rd_iss_hazard = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (q_fire && sel_rd && wq_vld[i] && same_gran(wq_addr[i], cmd_addr) &&
          seq_before(wq_seq[i], rq_seq[q_slot]))
        rd_iss_hazard = 1'b1;
  end

  mrq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W), .CW(CW)) u_wq (
    .clk(clk), .rst_n(rst_n), .push(wr_push), .push_addr(wr_addr), .push_id(wr_id),
    .push_seq(w_seq), .push_xdep('0), .pop_own(pop_w), .pop_x(pop_r),
    .ent_vld(wq_vld), .ent_addr(wq_addr), .ent_id(wq_id), .ent_seq(wq_seq),
    .ent_elig(wq_elig), .alloc_oh(wq_alloc), .cnt(wq_cnt), .full(wq_full), .empty(wq_empty)
  );

  mrq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W), .CW(CW)) u_rq (
    .clk(clk), .rst_n(rst_n), .push(rd_push), .push_addr(rd_addr), .push_id(rd_id),
    .push_seq(r_seq), .push_xdep(rd_xdep), .pop_own(pop_r), .pop_x(pop_w),
    .ent_vld(rq_vld), .ent_addr(rq_addr), .ent_id(rq_id), .ent_seq(rq_seq),
    .ent_elig(rq_elig), .alloc_oh(rq_alloc), .cnt(rq_cnt), .full(rq_full), .empty(rq_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= '0;
      last_row_q <= '0;
      last_vld_q <= 1'b0;
    end else begin
      seq_q <= seq_q + mrq_seq_t'(wr_acc) + mrq_seq_t'(rd_acc);
      if (cmd_fire) begin
        last_row_q <= row_of(cmd_addr);
        last_vld_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrq_chk.sv
module mrq_chk #(
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 32,
  parameter int ROW_LSB = 13,
  parameter int CW      = $clog2(DEPTH + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rd_ready,
  input logic                      cmd_valid,
  input logic [ADDR_W-1:0]         cmd_addr,
  input logic [CW-1:0]             rq_cnt,
  input logic [CW-1:0]             wq_cnt,
  input logic                      rd_push,
  input logic                      q_fire,
  input logic                      q_any,
  input logic                      sel_rd,
  input logic                      hit_any,
  input logic [ADDR_W-ROW_LSB-1:0] last_row_q,
  input logic                      rd_iss_hazard
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> rq_cnt == $past(rq_cnt) + CW'($past(rd_push)) - CW'($past(q_fire && sel_rd)));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cnt == CW'(DEPTH)) |-> !rd_ready);

  p_bypass_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !q_any) |-> (rq_cnt == '0 && wq_cnt == '0));

  p_row_pref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_fire && hit_any) |-> (cmd_addr[ADDR_W-1:ROW_LSB] == last_row_q));

  p_no_stale_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_fire && sel_rd) |-> !rd_iss_hazard);

  p_work_cons_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_cnt != '0 || wq_cnt != '0) |-> cmd_valid);
endmodule

bind mem_reorder_q mrq_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready), .cmd_valid(cmd_valid),
  .cmd_addr(cmd_addr), .rq_cnt(rq_cnt), .wq_cnt(wq_cnt), .rd_push(rd_push),
  .q_fire(q_fire), .q_any(q_any), .sel_rd(sel_rd), .hit_any(hit_any),
  .last_row_q(last_row_q), .rd_iss_hazard(rd_iss_hazard)
);

// File: tb/mem_reorder_q_tb.sv
module mem_reorder_q_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0, wr_valid = 1'b0, cmd_ready = 1'b0;
  logic [31:0] rd_addr = '0, wr_addr = '0;
  logic [3:0]  rd_id = '0, wr_id = '0;
  logic        rd_ready, wr_ready, cmd_valid, cmd_write;
  logic [31:0] cmd_addr;
  logic [3:0]  cmd_id;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic        w;
    logic [31:0] a;
    logic [3:0]  i;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  // granule of 16 KiB spans two 8 KiB rows, so the hazard rule can decide order
  mem_reorder_q #(.ADDR_W(32), .ID_W(4), .DEPTH(32), .GRAN_LG(14), .ROW_LSB(13)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_id(rd_id),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_id(wr_id),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_id(cmd_id)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic expect_cmd(input logic w, input logic [31:0] a, input logic [3:0] i, input string req);
    exp_t e;
    e.w = w; e.a = a; e.i = i; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor / scoreboard: samples just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rst_n && cmd_valid && cmd_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", $sformatf("unexpected cmd w=%0b a=%h id=%0d, expected none",
                                     cmd_write, cmd_addr, cmd_id));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cmd_write == e.w && cmd_addr == e.a && cmd_id == e.i, e.req,
              $sformatf("got w=%0b a=%h id=%0d, expected w=%0b a=%h id=%0d",
                        cmd_write, cmd_addr, cmd_id, e.w, e.a, e.i));
        end
      end
    end
  end

  task automatic put_rd(input logic [31:0] a, input logic [3:0] i);
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_id = i;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic put_wr(input logic [31:0] a, input logic [3:0] i);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_id = i;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    @(negedge clk);
    cmd_ready = 1'b1;
    for (int k = 0; k < 500 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, req, $sformatf("pending=%0d, expected 0", exp_q.size()));
    @(negedge clk);
    #1;
    chk(!cmd_valid, req, $sformatf("cmd_valid=%0b after drain, expected 0", cmd_valid));
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "R9", "watchdog expired, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!cmd_valid, "R1", $sformatf("cmd_valid=%0b, expected 0", cmd_valid));
    chk(rd_ready,   "R1", $sformatf("rd_ready=%0b, expected 1", rd_ready));
    chk(wr_ready,   "R1", $sformatf("wr_ready=%0b, expected 1", wr_ready));

    // R2 / R10: same-cycle path for a read and a write
    cmd_ready = 1'b1;
    expect_cmd(1'b0, 32'h40, 4'd1, "R2");
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 32'h40; rd_id = 4'd1;
    #1;
    chk(cmd_valid && !cmd_write && cmd_addr == 32'h40, "R2",
        $sformatf("v=%0b w=%0b a=%h, expected 1 0 40", cmd_valid, cmd_write, cmd_addr));
    @(negedge clk);
    rd_valid = 1'b0;
    #1;
    chk(!cmd_valid, "R2", $sformatf("cmd_valid=%0b after pass-through, expected 0", cmd_valid));
    expect_cmd(1'b1, 32'h1000, 4'd2, "R10");
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 32'h1000; wr_id = 4'd2;
    #1;
    chk(cmd_write, "R10", $sformatf("cmd_write=%0b, expected 1", cmd_write));
    @(negedge clk);
    wr_valid = 1'b0;

    // R4 / R5: previous row 0
    cmd_ready = 1'b0;
    put_rd(32'h4000, 4'd2);
    put_rd(32'h6000, 4'd3);
    put_rd(32'h0080, 4'd4);
    put_rd(32'h4100, 4'd5);
    #1;
    chk(cmd_valid, "R9", $sformatf("cmd_valid=%0b with queued work, expected 1", cmd_valid));
    expect_cmd(1'b0, 32'h0080, 4'd4, "R4");
    expect_cmd(1'b0, 32'h4000, 4'd2, "R5");
    expect_cmd(1'b0, 32'h4100, 4'd5, "R4");
    expect_cmd(1'b0, 32'h6000, 4'd3, "R5");
    drain("R5");

    // R6: set previous row 5, then read in row 5 behind older write in same granule
    cmd_ready = 1'b1;
    expect_cmd(1'b0, 32'hA100, 4'd7, "R2");
    put_rd(32'hA100, 4'd7);
    cmd_ready = 1'b0;
    put_wr(32'h8000, 4'd1);
    put_rd(32'hA040, 4'd2);
    expect_cmd(1'b1, 32'h8000, 4'd1, "R6");
    expect_cmd(1'b0, 32'hA040, 4'd2, "R6");
    drain("R6");

    // R7: younger same-ID read hits the row but must wait
    cmd_ready = 1'b0;
    put_rd(32'h2000, 4'd6);
    put_rd(32'hA080, 4'd6);
    put_rd(32'hA0C0, 4'd8);
    expect_cmd(1'b0, 32'hA0C0, 4'd8, "R4");
    expect_cmd(1'b0, 32'h2000, 4'd6, "R7");
    expect_cmd(1'b0, 32'hA080, 4'd6, "R7");
    drain("R7");
    cmd_ready = 1'b0;
    put_wr(32'h2000, 4'd3);
    put_wr(32'hA000, 4'd3);
    expect_cmd(1'b1, 32'h2000, 4'd3, "R7");
    expect_cmd(1'b1, 32'hA000, 4'd3, "R7");
    drain("R7");

    // R8: read and write in the same cycle, empty stores
    cmd_ready = 1'b1;
    expect_cmd(1'b1, 32'h40, 4'd2, "R8");
    expect_cmd(1'b0, 32'h0,  4'd1, "R8");
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = 32'h0;  rd_id = 4'd1;
    wr_valid = 1'b1; wr_addr = 32'h40; wr_id = 4'd2;
    #1;
    chk(cmd_valid && cmd_write, "R8",
        $sformatf("v=%0b w=%0b, expected 1 1", cmd_valid, cmd_write));
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b0;
    drain("R8");

    // R3: fill the read store, one write waits behind row hits
    cmd_ready = 1'b0;
    for (int k = 0; k < 32; k++) begin
      put_rd(32'(k * 64), 4'(k % 16));
      expect_cmd(1'b0, 32'(k * 64), 4'(k % 16), "R3");
    end
    #1;
    chk(!rd_ready, "R3", $sformatf("rd_ready=%0b with 32 held, expected 0", rd_ready));
    chk(wr_ready,  "R3", $sformatf("wr_ready=%0b, expected 1", wr_ready));
    chk(cmd_valid, "R9", $sformatf("cmd_valid=%0b, expected 1", cmd_valid));
    put_wr(32'h40000, 4'd9);
    expect_cmd(1'b1, 32'h40000, 4'd9, "R4");
    drain("R3");
    #1;
    chk(rd_ready, "R3", $sformatf("rd_ready=%0b after drain, expected 1", rd_ready));

    summary();
  end
endmodule